// File: doc/BRIEF.md
# Sequenced ADC Conversion Controller

This block is the digital sequencer of a single-shot analog-to-digital converter that sits on a simple 32-bit register port. Software programs one control word. The word selects one of eight channel inputs and one of two reference magnitudes. It also sets a clock divider and an interrupt enable, and it starts a conversion. A prescaled delay later, the block stores a scaled 10-bit result in a read-only data word. If the interrupt is enabled, it also raises a level interrupt, which stays up until software writes a 1 to the flag.

Each channel input is a 32-bit magnitude word. The two references are also magnitude ports. The result is the ratio of the channel magnitude to the chosen reference, scaled by 1024 and clipped at 1023. A sequential divider computes this ratio while the delay runs, so no wide combinational divide sits in the design. The channel, reference and magnitude operands are captured on the cycle the conversion starts. The control fields that decide what happens at completion (interrupt enable) are read when the conversion finishes.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After rst_n the control word reads 0x000C0001, the data word reads 0 and irq is low.
- R2: Byte offset 0x0 holds the control word and offset 0x4 holds the data word. A write to 0x4 or to any other offset changes nothing. A read from any other offset returns 0.
- R3: Control field positions: channel select bits 27:24, interrupt enable bit 21, reference select bit 19, interrupt flag bit 18, enable bit 17, soft reset bit 16, start/busy bit 13, divider bits 8:1. Every other bit reads back as last written.
- R4: Writing 1 to bit 18 clears the flag and drops irq. Writing 0 to bit 18 leaves a set flag set and irq high, whatever the other bits hold.
- R5: A control write with bit 16 set returns both words to their reset values, drops irq and cancels any running conversion, so no result lands later.
- R6: A conversion starts only on a control write that has bit 17 set and moves bit 13 from 0 to 1. No conversion starts if bit 17 is clear, or if bit 13 was already 1.
- R7: A control write with bit 17 set and bit 13 clear aborts a running conversion, so the data word keeps its old value.
- R8: The result lands 20 × 2 × (divider + 1) clock cycles after the clock edge that accepts the starting write. Until then, bit 13 reads 1 and the data word is unchanged.
- R9: The result equals floor(input × 1024 / reference), clipped to 1023. A reference of 0 gives 1023. Bit 19 = 1 selects int_ref and bit 19 = 0 selects ext_ref.
- R10: On completion, the data word takes the result and bit 13 clears. If bit 21 is set, the flag sets and irq rises. If bit 21 is clear, the flag and irq stay unchanged.
- R11: If the channel select is 8 or more, completion leaves the data word, the flag, irq and bit 13 unchanged.
- R12: The channel, reference and magnitude operands are sampled on the starting edge. Changes to them during the delay do not alter the result.
- R13: irq is high only while the flag (bit 18) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| chan_mag | input | 256 | Eight 32-bit channel magnitudes, channel 0 in the low bits |
| ext_ref | input | 32 | External reference magnitude |
| int_ref | input | 32 | Internal reference magnitude |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs every channel with both references and three divider settings. Some input magnitudes sit at, just below and well above the reference, and one case uses a zero reference. Each result is compared with an arithmetic model; a wrong clip or a wrong quotient width shows up as a bad data word. The data word is sampled one cycle before and exactly at the expected completion edge, so an off-by-one in the prescale count is caught. The bench then covers the corner cases:
- an out-of-range channel;
- a start while disabled;
- a start with no 0-to-1 edge;
- an abort;
- a soft reset mid-conversion;
- a flag written with 0;
- operands changed after the start.

A design that mishandled any of these would post a late result or lose a pending interrupt. It could also divide with whatever inputs hold at completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CTL_W      = 32;
    localparam int RES_W      = 10;
    localparam int CONV_CYC   = 20;
    localparam int B_CH_LO    = 24;
    localparam int CH_FLD_W   = 4;
    localparam int B_IE       = 21;
    localparam int B_REFSEL   = 19;
    localparam int B_FLAG     = 18;
    localparam int B_EN       = 17;
    localparam int B_SRST     = 16;
    localparam int B_START    = 13;
    localparam int B_DIV_LO   = 1;
    localparam logic [CTL_W-1:0] CTL_RST = 32'h000C_0001;
    localparam logic [RES_W-1:0] RES_MAX = {RES_W{1'b1}};

    typedef struct packed {
        logic [CTL_W-1:0] con;
        logic [CTL_W-1:0] data;
        logic             irq;
        logic             ch_ok;
    } ctl_state_t;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int DIV_W    = 8,
    parameter int CONV_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    input  logic [DIV_W-1:0] div,
    output logic             fire
);
    localparam int MAX_CNT = CONV_CYC * 2 * (2 ** DIV_W);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic [CNT_W-1:0] prescale;
    logic [CNT_W-1:0] load_val;

    assign prescale = CNT_W'({div, 1'b0}) + CNT_W'(2);
    assign load_val = CNT_W'(CONV_CYC) * prescale - CNT_W'(1);
    assign fire     = q.active && (q.cnt == '0);

    always_comb begin
        d = q;
        if (cancel) begin
            d.active = 1'b0;
        end else if (start) begin
            d.active = 1'b1;
            d.cnt    = load_val;
        end else if (fire) begin
            d.active = 1'b0;
        end else if (q.active) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_ratio_div.sv
module adc_ratio_div #(
    parameter int DW    = 32,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    num,
    input  logic [DW-1:0]    den,
    output logic [RES_W-1:0] quo,
    output logic             busy
);
    localparam int CW = $clog2(RES_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [DW-1:0]    rem;
        logic [RES_W-1:0] quo;
    } div_t;

    div_t q, d;
    logic [DW:0] trial;
    logic        take;

    assign trial = {q.rem, 1'b0};
    assign take  = trial >= {1'b0, q.busy ? den_q : '0};

    logic [DW-1:0] den_q;

    always_comb begin
        d = q;
        if (start) begin
            if (num >= den) begin
                d.busy = 1'b0;
                d.quo  = {RES_W{1'b1}};
                d.rem  = '0;
            end else begin
                d.busy = 1'b1;
                d.quo  = '0;
                d.rem  = num;
                d.cnt  = CW'(RES_W);
            end
        end else if (q.busy) begin
            d.rem = take ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
            d.quo = {q.quo[RES_W-2:0], take};
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            den_q <= '0;
        end else begin
            q <= d;
            if (start) den_q <= den;
        end
    end

    assign quo  = q.quo;
    assign busy = q.busy;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int MAG_W  = 32,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CTL_W-1:0]   wdata,
    output logic [CTL_W-1:0]   rdata,
    input  logic [NCH*MAG_W-1:0] chan_mag,
    input  logic [MAG_W-1:0]   ext_ref,
    input  logic [MAG_W-1:0]   int_ref,
    output logic               irq
);
    localparam int CH_IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [ADDR_W-1:0] OFS_CON  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);

    ctl_state_t st_q, st_d;

    logic [MAG_W-1:0] mag_arr [NCH];
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_mag
            assign mag_arr[g] = chan_mag[g*MAG_W +: MAG_W];
        end
    endgenerate

    logic             con_wr;
    logic [CH_FLD_W-1:0] ch_fld;
    logic             ch_in_range;
    logic [CH_IW-1:0] ch_idx;
    logic [MAG_W-1:0] op_num;
    logic [MAG_W-1:0] op_den;
    logic             conv_start;
    logic             conv_cancel;
    logic             tmr_fire;
    logic [RES_W-1:0] div_quo;
    logic             div_busy;

    assign con_wr      = wr_en && (addr == OFS_CON);
    assign ch_fld      = wdata[B_CH_LO +: CH_FLD_W];
    assign ch_in_range = {{(32-CH_FLD_W){1'b0}}, ch_fld} < 32'(NCH);
    assign ch_idx      = ch_fld[CH_IW-1:0];
    assign op_num      = ch_in_range ? mag_arr[ch_idx] : '0;
    assign op_den      = wdata[B_REFSEL] ? int_ref : ext_ref;

    always_comb begin
        logic [CTL_W-1:0] nc;
        st_d        = st_q;
        conv_start  = 1'b0;
        conv_cancel = 1'b0;
        nc          = wdata;
        if (con_wr) begin
            if (wdata[B_SRST]) begin
                st_d.con    = CTL_RST;
                st_d.data   = '0;
                st_d.irq    = 1'b0;
                st_d.ch_ok  = 1'b0;
                conv_cancel = 1'b1;
            end else begin
                if (wdata[B_FLAG]) begin
                    nc[B_FLAG] = 1'b0;
                    st_d.irq   = 1'b0;
                end else begin
                    nc[B_FLAG] = st_q.con[B_FLAG];
                end
                st_d.con = nc;
                if (nc[B_EN]) begin
                    if (nc[B_START] && !st_q.con[B_START]) begin
                        conv_start = 1'b1;
                        st_d.ch_ok = ch_in_range;
                    end else if (!nc[B_START]) begin
                        conv_cancel = 1'b1;
                    end
                end
            end
        end
        if (tmr_fire && !conv_cancel && !conv_start && st_q.ch_ok) begin
            st_d.data           = CTL_W'(div_quo);
            st_d.con[B_START]   = 1'b0;
            if (st_d.con[B_IE]) begin
                st_d.con[B_FLAG] = 1'b1;
                st_d.irq         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.con   <= CTL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    adc_conv_timer #(.DIV_W(DIV_W), .CONV_CYC(CONV_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .cancel (conv_cancel),
        .div    (wdata[B_DIV_LO +: DIV_W]),
        .fire   (tmr_fire)
    );

    adc_ratio_div #(.DW(MAG_W), .RES_W(RES_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .num   (op_num),
        .den   (op_den),
        .quo   (div_quo),
        .busy  (div_busy)
    );

    always_comb begin
        if (addr == OFS_CON)       rdata = st_q.con;
        else if (addr == OFS_DATA) rdata = st_q.data;
        else                       rdata = '0;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              irq,
    input logic [31:0]       con_q,
    input logic [31:0]       data_q,
    input logic              fire,
    input logic              div_busy
);
    a_r13_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> con_q[18]);

    a_r5_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && wdata[16])
        |=> (con_q == 32'h000C_0001 && data_q == 32'd0 && !irq));

    a_r2_data_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4) && !fire) |=> $stable(data_q));

    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && wdata[18] && !wdata[16] && !fire)
        |=> (!con_q[18] && !irq));

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && !wdata[18] && !wdata[16] && con_q[18])
        |=> con_q[18]);

    a_r9_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        data_q[31:10] == 22'd0);

    a_r8_div_done_first: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !div_busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .con_q    (st_q.con),
    .data_q   (st_q.data),
    .fire     (tmr_fire),
    .div_busy (div_busy)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] mag [8];
    logic [255:0] chan_mag;
    logic [31:0] ext_ref = 32'd1200000;
    logic [31:0] int_ref = 32'd2000000;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] dexp = 0;

    always #2 clk = ~clk;

    always_comb for (int i = 0; i < 8; i++) chan_mag[i*32 +: 32] = mag[i];

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chan_mag(chan_mag), .ext_ref(ext_ref), .int_ref(int_ref),
        .irq(irq)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(int ch, bit ie, bit rs, bit en, bit st, int dv);
        return 32'hA000_0201 | ((32'(ch) & 32'hF) << 24) | (32'(ie) << 21) |
               (32'(rs) << 19) | (32'(en) << 17) | (32'(st) << 13) |
               ((32'(dv) & 32'hFF) << 1);
    endfunction

    function automatic logic [31:0] expv(logic [31:0] x, logic [31:0] r);
        if (r == 0 || x >= r) return 32'd1023;
        return 32'((64'(x) * 64'd1024) / 64'(r));
    endfunction

    task automatic conv(int ch, bit ie, bit rs, int dv);
        logic [31:0] v, w0, w1, e;
        int n;
        w0 = mk(ch, ie, rs, 1, 0, dv);
        w1 = mk(ch, ie, rs, 1, 1, dv);
        e  = expv(mag[ch], rs ? int_ref : ext_ref);
        n  = 40 * (dv + 1);
        wr(12'h0, w0);
        wr(12'h0, w1);
        waitc(n - 1);
        rd(12'h4, v); chk("R8 data before completion", v, dexp);
        rd(12'h0, v); chk("R8 busy before completion", v[13], 1'b1);
        waitc(1);
        rd(12'h4, v); chk("R9 result", v, e);
        rd(12'h0, v); chk("R10 control after completion", v,
                          (w1 & ~32'h2000) | (ie ? 32'h0004_0000 : 32'h0));
        chk("R10 irq", irq, ie);
        dexp = e;
        if (ie) begin
            wr(12'h0, w0);
            rd(12'h0, v); chk("R4 flag sticky on zero write", v, w0 | 32'h0004_0000);
            chk("R4 irq held", irq, 1'b1);
            wr(12'h0, w0 | 32'h0004_0000);
            rd(12'h0, v); chk("R4 flag cleared by one", v, w0);
            chk("R4 irq dropped", irq, 1'b0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        mag[0] = 32'd0;       mag[1] = 32'd1;        mag[2] = 32'd600000;
        mag[3] = 32'd1199999; mag[4] = 32'd1200000;  mag[5] = 32'd1999999;
        mag[6] = 32'd2500000; mag[7] = 32'hFFFF_FFFF;
        waitc(3);
        rst_n = 1'b1;
        waitc(1);
        rd(12'h0, v); chk("R1 control reset", v, 32'h000C_0001);
        rd(12'h4, v); chk("R1 data reset", v, 32'h0);
        chk("R1 irq reset", irq, 1'b0);

        wr(12'h0, 32'h0004_0000);
        rd(12'h0, v); chk("R4 clear reset flag", v, 32'h0);
        chk("R3 unnamed bits readback", v[0], 1'b0);

        for (int dv = 0; dv < 4; dv++) begin
            if (dv == 2) continue;
            for (int ch = 0; ch < 8; ch++)
                for (int rs = 0; rs < 2; rs++)
                    conv(ch, ch[0], rs[0], dv);
        end

        // R11: out-of-range channel
        wr(12'h0, mk(8, 1, 0, 1, 0, 0));
        wr(12'h0, mk(8, 1, 0, 1, 1, 0));
        waitc(45);
        rd(12'h4, v); chk("R11 data kept", v, dexp);
        rd(12'h0, v); chk("R11 control kept", v, mk(8, 1, 0, 1, 1, 0));
        chk("R11 irq low", irq, 1'b0);

        // R7: abort
        wr(12'h0, mk(2, 0, 0, 1, 0, 0));
        wr(12'h0, mk(2, 0, 0, 1, 1, 0));
        waitc(5);
        wr(12'h0, mk(2, 0, 0, 1, 0, 0));
        waitc(50);
        rd(12'h4, v); chk("R7 abort keeps data", v, dexp);
        conv(2, 0, 0, 0);

        // R6: disabled start and missing edge
        wr(12'h0, mk(3, 0, 0, 0, 0, 0));
        wr(12'h0, mk(3, 0, 0, 0, 1, 0));
        waitc(45);
        rd(12'h4, v); chk("R6 no start while disabled", v, dexp);
        rd(12'h0, v); chk("R6 start bit kept", v, mk(3, 0, 0, 0, 1, 0));
        wr(12'h0, mk(3, 0, 0, 1, 1, 0));
        waitc(45);
        rd(12'h4, v); chk("R6 no start without edge", v, dexp);

        // R12: operands sampled at start
        wr(12'h0, mk(1, 0, 1, 1, 0, 0));
        wr(12'h0, mk(1, 0, 1, 1, 1, 0));
        waitc(2);
        mag[1] = 32'd1500000;
        int_ref = 32'd3;
        waitc(45);
        rd(12'h4, v); chk("R12 start-time operands", v, 32'd0);
        dexp = 0;
        mag[1] = 32'd1;
        int_ref = 32'd2000000;

        // R9: zero reference
        ext_ref = 32'd0;
        conv(0, 1, 0, 0);
        ext_ref = 32'd1200000;
        conv(6, 0, 0, 1);

        // R5: soft reset mid-conversion
        wr(12'h0, mk(2, 1, 0, 1, 0, 0));
        wr(12'h0, mk(2, 1, 0, 1, 1, 0));
        waitc(5);
        wr(12'h0, 32'h0001_2000);
        rd(12'h0, v); chk("R5 control reset", v, 32'h000C_0001);
        rd(12'h4, v); chk("R5 data reset", v, 32'h0);
        chk("R5 irq low", irq, 1'b0);
        waitc(45);
        rd(12'h4, v); chk("R5 no late result", v, 32'h0);
        chk("R13 irq stays low", irq, 1'b0);

        // R2: read-only data word and unmapped offsets
        wr(12'h4, 32'h0000_03FF);
        rd(12'h4, v); chk("R2 data write ignored", v, 32'h0);
        wr(12'h8, 32'hFFFF_FFFF);
        rd(12'h8, v); chk("R2 unmapped read zero", v, 32'h0);
        rd(12'h0, v); chk("R2 control untouched", v, 32'h000C_0001);

        finished = 1;
        summary();
    end
endmodule